// File: doc/BRIEF.md
# CAN status-change interrupt identifier

This block keeps the sticky "message sent" flag of one CAN controller channel and the status-change interrupt that goes with it. The protocol engine pulses `txOk` for each frame that went out without error and was acknowledged. The flag then stays set until software clears it, until the controller soft-reset strobe arrives, or until system reset.

A CPU reaches the block through a small register bus. Address 0 is the status register and address 1 is the interrupt identification register. The identification value names the highest-priority pending source. The status-change interrupt outranks everything. Below it come the message-center interrupts of the channel, which arrive as a vector of pending bits.

Reading the status register acknowledges the status-change interrupt. The identification value then falls back to the best remaining message-center source, or to zero. A software write that moves the flag from 0 to 1 raises an artificial status-change interrupt. The interrupt request line is high whenever the identification value is non-zero.

Top module: `canStatusIntId`

## Requirements
- R1: A cycle with `txOk` high sets the flag on the next clock edge. The flag appears at bit 3 of `statusReg`, and all other bits of `statusReg` are 0. No hardware event clears the flag.
- R2: The flag is cleared in three ways:
  - a bus write to address 0 with bit 3 of the data at 0;
  - `softReset` high, which takes effect on the next edge, clears both the flag and the pending interrupt, and overrides every other input;
  - `rstN` low.
  After reset the flag and the pending interrupt are 0.
- R3: With `statIntEn` high, a `txOk` pulse makes the status interrupt pending from the next edge, and `intId` then reads 01h. This holds even when the flag is already 1.
- R4: A bus read of address 0 clears the pending status interrupt on the next edge. A read of address 1 leaves it pending.
- R5: When no status interrupt is pending, `intId` is 00h if `mcPending` is all zero. Otherwise `intId` is 02h plus the index of the lowest set bit of `mcPending`. `intId` follows `mcPending` in the same cycle, without a clock edge.
- R6: A bus write to address 0 with bit 3 set, while the flag is 0 and `statIntEn` is high, sets the flag and raises the pending status interrupt. The same write while the flag is already 1 raises no interrupt.
- R7: When `txOk` and a status read fall in the same cycle, the pending interrupt stays set. When `txOk` and a write that clears the flag fall in the same cycle, the flag ends up set.
- R8: With `statIntEn` low, neither `txOk` nor a software write that sets the flag raises the status interrupt, but the flag is still set.
- R9: `irq` is high exactly when `intId` is non-zero. Bus writes to address 1 change neither `statusReg` nor `intId`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| txOk | input | 1 | One-cycle pulse: a frame was sent error-free and acknowledged |
| busAddr | input | 1 | Register select: 0 is status, 1 is identification |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWData | input | 8 | Write data |
| statIntEn | input | 1 | Enable for the status-change interrupt |
| softReset | input | 1 | Controller soft-reset strobe |
| mcPending | input | 15 | Pending message-center interrupts, bit 0 highest priority |
| statusReg | output | 8 | Status register value |
| intId | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
Hardware pulses are applied with the flag clear and with the flag already set, which separates the edge-triggered interrupt from level-triggered behaviour. Software writes of 1 are made with the flag at 0 and at 1 to show that only a rising write raises the artificial interrupt. Message-center patterns with one, several and no bits set, applied while the status interrupt is pending and after it is acknowledged, test the priority order and the fallback code. Same-cycle collisions (pulse with read, pulse with clearing write, soft reset with pulse) test the precedence rules.

// File: rtl/canStatPkg.sv
package canStatPkg;
  typedef struct packed {
    logic clrAll;
    logic flagSet;
    logic flagWr;
    logic flagWrVal;
    logic pendSet;
    logic pendClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/canStatCtrl.sv
module canStatCtrl
  import canStatPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 3,
  parameter logic STATUS_ADDR = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txOk,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWData,
  input  logic              statIntEn,
  input  logic              softReset,
  input  logic              flagQ,
  output ctrlStrobes_t      strobes
);
  logic wrStatus;
  logic rdStatus;
  logic wrBit;
  logic swRise;

  always_comb begin
    wrStatus = busWr && (busAddr == STATUS_ADDR);
    rdStatus = busRd && (busAddr == STATUS_ADDR);
    wrBit    = busWData[FLAG_BIT];
    swRise   = wrStatus && wrBit && !flagQ;
    strobes.clrAll    = softReset;
    strobes.flagSet   = txOk;
    strobes.flagWr    = wrStatus;
    strobes.flagWrVal = wrBit;
    strobes.pendSet   = statIntEn && (txOk || swRise);
    strobes.pendClr   = rdStatus;
  end

  // R6: a write of 1 while the flag is set never requests a new interrupt
  p_no_rearm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && wrBit && flagQ && !txOk) |-> !strobes.pendSet);

  // R8: a disabled status interrupt never requests a set
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statIntEn |-> !strobes.pendSet);
endmodule

// File: rtl/canStatDatapath.sv
module canStatDatapath
  import canStatPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 3,
  parameter int NUM_MC = 15,
  parameter int ID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_MC-1:0] mcPending,
  output logic              flagQ,
  output logic              pendQ,
  output logic [DATA_W-1:0] statusReg,
  output logic [ID_W-1:0]   intId,
  output logic              irq
);
  localparam logic [ID_W-1:0] STAT_CODE = ID_W'(1);
  localparam int MC_BASE = 2;

  logic [ID_W-1:0] mcCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      pendQ <= 1'b0;
    end else if (strobes.clrAll) begin
      flagQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (strobes.flagSet)     flagQ <= 1'b1;
      else if (strobes.flagWr) flagQ <= strobes.flagWrVal;
      if (strobes.pendSet)      pendQ <= 1'b1;
      else if (strobes.pendClr) pendQ <= 1'b0;
    end
  end

  always_comb begin
    mcCode = '0;
    for (int i = NUM_MC - 1; i >= 0; i--) begin
      if (mcPending[i]) mcCode = ID_W'(i + MC_BASE);
    end
  end

  always_comb begin
    statusReg = '0;
    statusReg[FLAG_BIT] = flagQ;
    intId = pendQ ? STAT_CODE : mcCode;
    irq = (intId != '0);
  end

  // R1: the hardware set always lands
  p_hw_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagSet && !strobes.clrAll) |=> flagQ);

  // R1: no hardware path clears the flag
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobes.clrAll && !strobes.flagWr) |=> flagQ);

  // R2: the soft reset clears everything
  p_soft_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAll |=> (!flagQ && !pendQ));

  // R4: an acknowledge with no new event drops the pending interrupt
  p_rd_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pendClr && !strobes.pendSet) |=> !pendQ);

  // R7: a new event beats a same-cycle acknowledge
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pendSet && !strobes.clrAll) |=> (pendQ && intId == STAT_CODE));
endmodule

// File: rtl/canStatusIntId.sv
module canStatusIntId
  import canStatPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 3,
  parameter int NUM_MC = 15,
  parameter int ID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txOk,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWData,
  input  logic              statIntEn,
  input  logic              softReset,
  input  logic [NUM_MC-1:0] mcPending,
  output logic [DATA_W-1:0] statusReg,
  output logic [ID_W-1:0]   intId,
  output logic              irq
);
  ctrlStrobes_t strobes;
  logic flagQ;
  logic pendQ;

  canStatCtrl #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .STATUS_ADDR(1'b0)) ctrl_i (
    .clk(clk), .rstN(rstN), .txOk(txOk), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWData(busWData), .statIntEn(statIntEn),
    .softReset(softReset), .flagQ(flagQ), .strobes(strobes)
  );

  canStatDatapath #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT), .NUM_MC(NUM_MC), .ID_W(ID_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mcPending(mcPending),
    .flagQ(flagQ), .pendQ(pendQ), .statusReg(statusReg), .intId(intId), .irq(irq)
  );

  // R9: any pending message-center source raises the request line
  p_mc_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mcPending != '0) |-> irq);

  // R5: with nothing pending anywhere the identification value is zero
  p_idle_id_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pendQ && mcPending == '0) |-> (intId == '0 && !irq));
endmodule

// File: tb/canStatusIntId_tb_top.sv
module canStatusIntId_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txOk = 1'b0, busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWData = '0;
  logic statIntEn = 1'b0, softReset = 1'b0;
  logic [14:0] mcPending = '0;
  logic [7:0] statusReg, intId;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit mFlag = 0;
  bit mPend = 0;
  bit compareOn = 0;

  always #5 clk = ~clk;

  canStatusIntId dut_i (
    .clk(clk), .rstN(rstN), .txOk(txOk), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWData(busWData), .statIntEn(statIntEn),
    .softReset(softReset), .mcPending(mcPending),
    .statusReg(statusReg), .intId(intId), .irq(irq)
  );

  // Behavioural reference: written from the requirements.
  always @(posedge clk) begin
    bit oldFlag;
    oldFlag = mFlag;
    if (!rstN || softReset) begin
      mFlag <= 0;
      mPend <= 0;
    end else begin
      if (txOk) mFlag <= 1;
      else if (busWr && busAddr == 1'b0) mFlag <= busWData[3];
      if (statIntEn && (txOk || (busWr && busAddr == 1'b0 && busWData[3] && !oldFlag)))
        mPend <= 1;
      else if (busRd && busAddr == 1'b0)
        mPend <= 0;
    end
  end

  function automatic int refId();
    if (mPend) return 1;
    for (int i = 0; i < 15; i++) if (mcPending[i]) return i + 2;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn) begin
      check("R1 model statusReg", statusReg, {4'b0, mFlag, 3'b0});
      check("R5 model intId", intId, refId());
      check("R9 model irq", irq, refId() != 0);
    end
  end

  task automatic idle();
    txOk = 0; busWr = 0; busRd = 0; softReset = 0; busWData = '0; busAddr = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset statusReg", statusReg, 0);
    check("R2 reset intId", intId, 0);
    rstN = 1;
    @(negedge clk);
    #1;
    compareOn = 1;
    statIntEn = 1;

    txOk = 1; step();
    check("R1 hw set flag", statusReg, 8'h08);
    check("R3 id after tx", intId, 1);
    check("R9 irq high", irq, 1);

    busRd = 1; busAddr = 1; step();
    check("R4 id read keeps pending", intId, 1);

    mcPending = 15'b000_0010_0010_0000;
    #1;
    check("R3 status outranks mc", intId, 1);
    busRd = 1; busAddr = 0; step();
    check("R4 read clears, fallback", intId, 7);
    check("R1 flag sticky after read", statusReg, 8'h08);

    mcPending = 15'b100_0000_0000_0000;
    #1;
    check("R5 highest index code", intId, 16);
    mcPending = '0;
    #1;
    check("R5 none pending", intId, 0);
    check("R9 irq low", irq, 0);

    txOk = 1; step();
    check("R3 rearm with flag set", intId, 1);
    busRd = 1; step();
    check("R4 cleared", intId, 0);

    busWr = 1; busWData = 8'h08; step();
    check("R6 write 1 over 1 no int", intId, 0);

    busWr = 1; busWData = 8'h00; step();
    check("R2 sw clear", statusReg, 0);

    busWr = 1; busWData = 8'h08; step();
    check("R6 sw rise flag", statusReg, 8'h08);
    check("R6 sw rise int", intId, 1);

    txOk = 1; busRd = 1; step();
    check("R7 event beats read", intId, 1);

    busWr = 1; busAddr = 1; busWData = 8'h00; step();
    check("R9 id write ignored status", statusReg, 8'h08);
    check("R9 id write ignored id", intId, 1);

    softReset = 1; txOk = 1; step();
    check("R2 soft reset flag", statusReg, 0);
    check("R2 soft reset id", intId, 0);

    txOk = 1; busWr = 1; busWData = 8'h00; step();
    check("R7 tx beats clear write", statusReg, 8'h08);
    busRd = 1; step();
    busWr = 1; busWData = 8'h00; step();

    statIntEn = 0;
    txOk = 1; step();
    check("R8 flag set when disabled", statusReg, 8'h08);
    check("R8 no int when disabled", intId, 0);
    busWr = 1; busWData = 8'h00; step();
    busWr = 1; busWData = 8'h08; step();
    check("R8 no sw int when disabled", intId, 0);

    statIntEn = 1;
    for (int k = 0; k < 40; k++) begin
      txOk = (k % 7 == 0);
      busRd = (k % 3 == 0);
      busWr = (k % 5 == 1);
      busAddr = (k % 11 == 4);
      busWData = (k % 2) ? 8'h08 : 8'h00;
      mcPending = 15'(k * 37);
      softReset = (k == 29);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule